// File: doc/BRIEF.md
# Configurable ADC Output Serializer

This block turns pairs of 16-bit converter samples (channel A and channel B) into a serial output stream. Each sample is first reshaped to a programmable word size of 14, 16, 18 or 20 bits. It is then shifted out MSB first over one of three lane arrangements: two lanes per channel, one lane per channel, or a single lane shared by both channels. Beside the data, the block drives a frame clock that marks word boundaries and a bit clock that toggles on every fast clock cycle, so the data can be captured on both edges.

The block runs on the fast bit-rate clock, with one output bit per lane per cycle. Samples arrive on a one-cycle valid strobe, together with a 4-bit low-order extension that only the averaging source path fills. Resolution and lane arrangement are static inputs. A change is picked up when the next frame is loaded, so a frame already on the wire is never cut short or reshaped. If a sample arrives while a complete frame is still waiting to be loaded, the sample is discarded and an error pulse is raised.

Top module: `adc_out_serializer`

## Requirements
- R1: With `res_sel` = 2'b01 the word is 14 bits long: sample bits 15 down to 2, with the two lowest sample bits dropped and no rounding.
- R2: With `res_sel` = 2'b10 the word is the 16-bit sample unchanged.
- R3: At 18 bits (the sample followed by the top 2 extension bits) and at 20 bits (the sample followed by all 4 extension bits), the extension bits are used only when `avg_en` is 1. When `avg_en` is 0 those positions are sent as 0.
- R4: The resolution code 2'b00, the value a cleared setting holds, selects 18 bits. Code 2'b11 selects 20 bits.
- R5: `lane_sel` 2'b00 (and 2'b11): channel A on `lane_a0` and B on `lane_b0`, one sample per frame, frame length R cycles. 2'b01: two samples per frame, each of R cycles, with the first sample of A on `lane_a0`, the second on `lane_a1`, and likewise B on `lane_b0`/`lane_b1`. 2'b10: A then B back to back on `lane_a0`, frame length 2R. Lanes that a mode does not use stay 0.
- R6: Bits go out MSB first. The first bit appears in the cycle in which `fclk` rises. `fclk` is high for the first half of the frame and low for the second half. While no frame is running, `fclk` and all lanes are 0.
- R7: `dclk` inverts on every clock cycle after reset, so each new data bit lines up with one of its edges.
- R8: Resolution, lane mode and `avg_en` are taken when a frame is loaded. Changing them in mid-frame leaves the current frame unchanged.
- R9: A frame loads one cycle after its last required sample is captured if the serializer is idle. Otherwise it loads in the cycle right after the previous frame's last bit, with no gap. Every accepted frame is delivered.
- R10: A valid strobe that arrives while a complete frame is waiting, and that frame is not loaded in the same cycle, is dropped. `ovr_err` then pulses for one cycle on the next cycle. A strobe in the cycle in which the waiting frame loads is accepted.
- R11: Right after reset, every lane, `fclk` and `ovr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe: a new sample pair is present |
| smp_a | input | 16 | Channel A sample |
| smp_b | input | 16 | Channel B sample |
| ext_a | input | 4 | Channel A low-order extension (averaging path) |
| ext_b | input | 4 | Channel B low-order extension (averaging path) |
| avg_en | input | 1 | Use the extension bits as output LSBs |
| res_sel | input | 2 | Resolution code: 00=18, 01=14, 10=16, 11=20 |
| lane_sel | input | 2 | Lane mode: 00 one per channel, 01 two per channel, 10 shared, 11 as 00 |
| lane_a0 | output | 1 | Serial lane 0 of channel A (shared lane in mode 10) |
| lane_a1 | output | 1 | Serial lane 1 of channel A |
| lane_b0 | output | 1 | Serial lane 0 of channel B |
| lane_b1 | output | 1 | Serial lane 1 of channel B |
| fclk | output | 1 | Frame clock |
| dclk | output | 1 | Double-data-rate bit clock |
| ovr_err | output | 1 | One-cycle pulse: a sample was dropped |

## Verification
Two functions can act in the same cycle: the loading of a waiting frame into the serializer and the capture of a new sample into the input buffer. The bench provokes this with three valid strobes on consecutive cycles while the block is idle. The second strobe coincides with the load of the first frame and must be accepted. The third finds a full buffer with the serializer busy and must be dropped. The scoreboard expects exactly two frames, the second starting exactly one frame length after the first, and a single error pulse.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

  localparam int SMP_W     = 16;
  localparam int EXT_W     = 4;
  localparam int WORD_W    = SMP_W + EXT_W;
  localparam int LANE_W    = 2 * WORD_W;
  localparam int NUM_LANES = 4;
  localparam int CNT_W     = $clog2(LANE_W + 1);

  typedef enum logic [1:0] {
    RES_18 = 2'b00,
    RES_14 = 2'b01,
    RES_16 = 2'b10,
    RES_20 = 2'b11
  } res_e;

  typedef enum logic [1:0] {
    LM_ONE  = 2'b00,
    LM_TWO  = 2'b01,
    LM_HALF = 2'b10,
    LM_RSV  = 2'b11
  } lane_e;

  typedef struct packed {
    logic [SMP_W-1:0] smp;
    logic [EXT_W-1:0] ext;
  } chan_s;

  typedef struct packed {
    chan_s a;
    chan_s b;
  } pair_s;

  // word length in bits for a resolution code
  function automatic logic [CNT_W-1:0] res_bits(res_e r);
    case (r)
      RES_14:  res_bits = CNT_W'(14);
      RES_16:  res_bits = CNT_W'(16);
      RES_20:  res_bits = CNT_W'(20);
      default: res_bits = CNT_W'(18);
    endcase
  endfunction

  // left-aligned output word; positions below the resolution are zero
  function automatic logic [WORD_W-1:0] map_word(chan_s c, logic avg, res_e r);
    logic [WORD_W-1:0] w;
    w = {c.smp, (avg ? c.ext : {EXT_W{1'b0}})};
    case (r)
      RES_14:  map_word = {w[WORD_W-1 -: 14], 6'b0};
      RES_16:  map_word = {w[WORD_W-1 -: 16], 4'b0};
      RES_18:  map_word = {w[WORD_W-1 -: 18], 2'b0};
      default: map_word = w;
    endcase
  endfunction

  // frame length in bit-clock cycles
  function automatic logic [CNT_W-1:0] frame_len(res_e r, lane_e m);
    frame_len = (m == LM_HALF) ? CNT_W'(res_bits(r) << 1) : res_bits(r);
  endfunction

  // samples gathered per frame
  function automatic logic [1:0] slots_needed(lane_e m);
    slots_needed = (m == LM_TWO) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/adcser_buffer.sv
module adcser_buffer
  import adcser_pkg::*;
#(
  parameter int NSLOT = 2,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  pair_s                smp_in,
  input  lane_e                mode_req,
  input  logic                 launch,
  output pair_s [NSLOT-1:0]    slots,
  output logic                 buf_full,
  output logic                 ovr_err
);

  logic [CW-1:0] count;
  logic          ovr_evt;

  assign buf_full = (count >= CW'(slots_needed(mode_req)));
  assign ovr_evt  = smp_vld && buf_full && !launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      ovr_err <= 1'b0;
      slots   <= '0;
    end else begin
      ovr_err <= ovr_evt;
      if (launch) begin
        count <= smp_vld ? CW'(1) : '0;
        if (smp_vld) slots[0] <= smp_in;
      end else if (smp_vld && !buf_full) begin
        for (int i = 0; i < NSLOT; i++) begin
          if (count == CW'(i)) slots[i] <= smp_in;
        end
        count <= count + CW'(1);
      end
    end
  end

endmodule

// File: rtl/adcser_mapper.sv
module adcser_mapper
  import adcser_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  pair_s [NSLOT-1:0]                 slots,
  input  res_e                              res,
  input  lane_e                             mode,
  input  logic                              avg,
  output logic [NUM_LANES-1:0][LANE_W-1:0]  load_w
);

  localparam logic [WORD_W-1:0] ZW = '0;

  logic [NSLOT-1:0][WORD_W-1:0] ma;
  logic [NSLOT-1:0][WORD_W-1:0] mb;
  logic [CNT_W-1:0]             rb;
  logic [LANE_W-1:0]            shared_w;

  for (genvar s = 0; s < NSLOT; s++) begin : g_map
    assign ma[s] = map_word(slots[s].a, avg, res);
    assign mb[s] = map_word(slots[s].b, avg, res);
  end

  assign rb       = res_bits(res);
  assign shared_w = {ma[0], ZW} | ({mb[0], ZW} >> rb);

  always_comb begin
    load_w = '0;
    case (mode)
      LM_TWO: begin
        load_w[0] = {ma[0], ZW};
        load_w[1] = {ma[1], ZW};
        load_w[2] = {mb[0], ZW};
        load_w[3] = {mb[1], ZW};
      end
      LM_HALF: load_w[0] = shared_w;
      default: begin
        load_w[0] = {ma[0], ZW};
        load_w[2] = {mb[0], ZW};
      end
    endcase
  end

endmodule

// File: rtl/adcser_shifter.sv
module adcser_shifter
  import adcser_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              launch,
  input  logic [NUM_LANES-1:0][LANE_W-1:0]  load_w,
  input  logic [CNT_W-1:0]                  len_new,
  output logic                              busy,
  output logic [CNT_W-1:0]                  frm_cnt,
  output logic [CNT_W-1:0]                  frm_len,
  output logic                              frm_last,
  output logic [NUM_LANES-1:0]              lane_bits
);

  assign frm_last = busy && (frm_cnt == frm_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      frm_cnt <= '0;
      frm_len <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      frm_cnt <= '0;
      frm_len <= len_new;
    end else if (busy) begin
      if (frm_last) busy <= 1'b0;
      else          frm_cnt <= frm_cnt + CNT_W'(1);
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst)         sh <= '0;
      else if (launch) sh <= load_w[l];
      else if (busy)   sh <= {sh[LANE_W-2:0], 1'b0};
    end
    assign lane_bits[l] = busy && sh[LANE_W-1];
  end

endmodule

// File: rtl/adcser_clkgen.sv
module adcser_clkgen
  import adcser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [CNT_W-1:0] frm_cnt,
  input  logic [CNT_W-1:0] frm_len,
  output logic             fclk,
  output logic             dclk
);

  always_ff @(posedge clk) begin
    if (rst) dclk <= 1'b0;
    else     dclk <= ~dclk;
  end

  assign fclk = busy && (frm_cnt < (frm_len >> 1));

endmodule

// File: rtl/adc_out_serializer.sv
module adc_out_serializer
  import adcser_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_a,
  input  logic [SMP_W-1:0] smp_b,
  input  logic [EXT_W-1:0] ext_a,
  input  logic [EXT_W-1:0] ext_b,
  input  logic             avg_en,
  input  logic [1:0]       res_sel,
  input  logic [1:0]       lane_sel,
  output logic             lane_a0,
  output logic             lane_a1,
  output logic             lane_b0,
  output logic             lane_b1,
  output logic             fclk,
  output logic             dclk,
  output logic             ovr_err
);

  res_e  res_req;
  lane_e mode_req;
  pair_s smp_in;

  assign res_req  = res_e'(res_sel);
  assign mode_req = lane_e'(lane_sel);
  assign smp_in   = '{a: '{smp: smp_a, ext: ext_a}, b: '{smp: smp_b, ext: ext_b}};

  // named internal events, observed by the bound checker
  logic                             launch;
  logic                             buf_full;
  logic                             busy;
  logic                             frm_last;
  logic [CNT_W-1:0]                 frm_cnt;
  logic [CNT_W-1:0]                 frm_len;
  res_e                             act_res;
  lane_e                            act_mode;
  pair_s [NSLOT-1:0]                slots;
  logic [NUM_LANES-1:0][LANE_W-1:0] load_w;
  logic [NUM_LANES-1:0]             lane_bits;

  assign launch = buf_full && (!busy || frm_last);

  adcser_buffer #(.NSLOT(NSLOT)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_in   (smp_in),
    .mode_req (mode_req),
    .launch   (launch),
    .slots    (slots),
    .buf_full (buf_full),
    .ovr_err  (ovr_err)
  );

  adcser_mapper #(.NSLOT(NSLOT)) u_map (
    .slots  (slots),
    .res    (res_req),
    .mode   (mode_req),
    .avg    (avg_en),
    .load_w (load_w)
  );

  adcser_shifter u_shf (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .load_w    (load_w),
    .len_new   (frame_len(res_req, mode_req)),
    .busy      (busy),
    .frm_cnt   (frm_cnt),
    .frm_len   (frm_len),
    .frm_last  (frm_last),
    .lane_bits (lane_bits)
  );

  adcser_clkgen u_clk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .frm_cnt (frm_cnt),
    .frm_len (frm_len),
    .fclk    (fclk),
    .dclk    (dclk)
  );

  // configuration in force for the frame on the wire
  always_ff @(posedge clk) begin
    if (rst) begin
      act_res  <= RES_18;
      act_mode <= LM_ONE;
    end else if (launch) begin
      act_res  <= res_req;
      act_mode <= mode_req;
    end
  end

  assign lane_a0 = lane_bits[0];
  assign lane_a1 = lane_bits[1];
  assign lane_b0 = lane_bits[2];
  assign lane_b1 = lane_bits[3];

endmodule

// File: rtl/adcser_chk.sv
module adcser_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_vld,
  input logic       buf_full,
  input logic       launch,
  input logic       busy,
  input logic [5:0] frm_cnt,
  input logic [5:0] frm_len,
  input logic [1:0] act_res,
  input logic [1:0] act_mode,
  input logic       lane_a0,
  input logic       lane_a1,
  input logic       lane_b0,
  input logic       lane_b1,
  input logic       fclk,
  input logic       dclk,
  input logic       ovr_err
);

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R10
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_err |-> $past(smp_vld) && $past(buf_full) && !$past(launch));

  // R5
  half_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (act_mode == 2'b10) |-> !lane_a1 && !lane_b0 && !lane_b1);

  // R5
  one_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (act_mode == 2'b00 || act_mode == 2'b11) |-> !lane_a1 && !lane_b1);

  // R6
  fclk_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fclk) |-> $past(launch));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fclk && !lane_a0 && !lane_a1 && !lane_b0 && !lane_b1);

  // R7
  dclk_toggle_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    dclk != $past(dclk));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !launch |=> $stable(act_res) && $stable(act_mode));

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> frm_cnt < frm_len);

endmodule

bind adc_out_serializer adcser_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_vld  (smp_vld),
  .buf_full (buf_full),
  .launch   (launch),
  .busy     (busy),
  .frm_cnt  (frm_cnt),
  .frm_len  (frm_len),
  .act_res  (act_res),
  .act_mode (act_mode),
  .lane_a0  (lane_a0),
  .lane_a1  (lane_a1),
  .lane_b0  (lane_b0),
  .lane_b1  (lane_b1),
  .fclk     (fclk),
  .dclk     (dclk),
  .ovr_err  (ovr_err)
);

// File: tb/adc_out_serializer_tb.sv
module adc_out_serializer_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [15:0] smp_a = '0, smp_b = '0;
  logic [3:0] ext_a = '0, ext_b = '0;
  logic avg_en = 1'b0;
  logic [1:0] res_sel = 2'b00, lane_sel = 2'b00;
  logic lane_a0, lane_a1, lane_b0, lane_b1, fclk, dclk, ovr_err;

  always #5 clk = ~clk;

  adc_out_serializer u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_a(smp_a), .smp_b(smp_b),
    .ext_a(ext_a), .ext_b(ext_b), .avg_en(avg_en), .res_sel(res_sel),
    .lane_sel(lane_sel), .lane_a0(lane_a0), .lane_a1(lane_a1),
    .lane_b0(lane_b0), .lane_b1(lane_b1), .fclk(fclk), .dclk(dclk),
    .ovr_err(ovr_err)
  );

  typedef struct {
    int          len;
    logic [39:0] w [4];
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0, cyc = 0, err_seen = 0;
  int last_start = 0, prev_start = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // word length from the resolution code (R4)
  function automatic int rbits(logic [1:0] c);
    return (c == 2'b01) ? 14 : (c == 2'b10) ? 16 : (c == 2'b11) ? 20 : 18;
  endfunction

  // R1 R2 R3: keep the top R bits of {sample, ext-or-zero}
  function automatic logic [19:0] emap(logic [15:0] s, logic [3:0] e);
    logic [19:0] full;
    full = {s, avg_en ? e : 4'h0};
    return full & ~(20'hFFFFF >> rbits(res_sel));
  endfunction

  function automatic logic [15:0] gs(int k);
    return 16'h9A3C ^ 16'(k * 16'h3B1D);
  endfunction

  function automatic logic [3:0] ge(int k);
    return 4'(k) ^ 4'hA;
  endfunction

  // expected frame for one sample pair (modes 00 and 10)
  task automatic push_one(int k, string tag);
    exp_t it;
    logic [19:0] ma, mb;
    int r;
    r  = rbits(res_sel);
    ma = emap(gs(k), ge(k));
    mb = emap(gs(k + 500), ge(k + 7));
    foreach (it.w[i]) it.w[i] = '0;
    it.tag = tag;
    if (lane_sel == 2'b10) begin
      it.len  = 2 * r;
      it.w[0] = {ma, 20'h0};
      for (int i = 0; i < r; i++) it.w[0][39 - r - i] = mb[19 - i];
    end else begin
      it.len  = r;
      it.w[0] = {ma, 20'h0};
      it.w[2] = {mb, 20'h0};
    end
    q.push_back(it);
  endtask

  // expected frame for two consecutive pairs (mode 01)
  task automatic push_two(int k, string tag);
    exp_t it;
    it.len  = rbits(res_sel);
    it.tag  = tag;
    it.w[0] = {emap(gs(k), ge(k)), 20'h0};
    it.w[1] = {emap(gs(k + 1), ge(k + 1)), 20'h0};
    it.w[2] = {emap(gs(k + 500), ge(k + 7)), 20'h0};
    it.w[3] = {emap(gs(k + 501), ge(k + 8)), 20'h0};
    q.push_back(it);
  endtask

  task automatic drive(int k);
    smp_vld = 1'b1;
    smp_a = gs(k); smp_b = gs(k + 500);
    ext_a = ge(k); ext_b = ge(k + 7);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_one(int n, int per, int base, string tag);
    for (int k = 0; k < n; k++) begin
      push_one(base + k, tag);
      drive(base + k);
      idle(per - 1);
    end
  endtask

  task automatic run_two(int n, int per, int base, string tag);
    for (int k = 0; k < n; k++) begin
      push_two(base + 2 * k, tag);
      drive(base + 2 * k);
      idle(per - 1);
      drive(base + 2 * k + 1);
      idle(per - 1);
    end
  endtask

  task automatic drain(int err_exp, string tag);
    idle(100);
    check(q.size() == 0, {"R9 frames delivered ", tag}, 64'(q.size()), 64'd0);
    check(err_seen == err_exp, {"R10 error count ", tag}, 64'(err_seen), 64'(err_exp));
  endtask

  // scoreboard monitor
  exp_t cur;
  logic [39:0] rx [4];
  int idx = 0, fhi = 0;
  bit in_fr = 0;
  logic fprev = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      fprev = 1'b0; in_fr = 0;
    end else begin
      if (ovr_err) err_seen++;
      if (fclk && !fprev) begin
        if (in_fr) check(0, "R9 frame cut short", 64'(idx), 64'(cur.len));
        if (q.size() == 0) begin
          check(0, "R9 unexpected frame", 64'd1, 64'd0);
          in_fr = 0;
        end else begin
          cur = q.pop_front();
          in_fr = 1; idx = 0; fhi = 0;
          foreach (rx[i]) rx[i] = '0;
          prev_start = last_start;
          last_start = cyc;
        end
      end
      if (in_fr) begin
        rx[0][39 - idx] = lane_a0;
        rx[1][39 - idx] = lane_a1;
        rx[2][39 - idx] = lane_b0;
        rx[3][39 - idx] = lane_b1;
        if (fclk) fhi++;
        idx++;
        if (idx == cur.len) begin
          for (int l = 0; l < 4; l++)
            if (rx[l] != cur.w[l])
              check(0, {"R6 lane data ", cur.tag}, 64'(rx[l]), 64'(cur.w[l]));
          check(fhi == cur.len / 2, {"R6 fclk high half ", cur.tag}, 64'(fhi), 64'(cur.len / 2));
          in_fr = 0;
        end
      end
      fprev = fclk;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic d0;
    idle(5);
    rst = 1'b0;
    idle(2);
    // R11 reset state
    check({lane_a0, lane_a1, lane_b0, lane_b1, fclk, ovr_err} == 6'b0, "R11 reset outputs",
          64'({lane_a0, lane_a1, lane_b0, lane_b1, fclk, ovr_err}), 64'd0);
    // R7 bit clock inverts each cycle
    d0 = dclk; idle(1);
    check(dclk != d0, "R7 dclk toggle", 64'(dclk), 64'(!d0));
    d0 = dclk; idle(1);
    check(dclk != d0, "R7 dclk toggle", 64'(dclk), 64'(!d0));

    // R4 R3: code 00 is 18 bits, ext ignored without averaging, one lane per channel (R5)
    res_sel = 2'b00; lane_sel = 2'b00; avg_en = 1'b0;
    run_one(4, 18, 0, "R4 18b default");
    drain(0, "R4");
    // R1: 14-bit truncation
    res_sel = 2'b01;
    run_one(3, 14, 10, "R1 14b");
    drain(0, "R1");
    // R2 R5: 16 bits, two lanes per channel
    res_sel = 2'b10; lane_sel = 2'b01;
    run_two(3, 8, 20, "R2 16b two-lane");
    drain(0, "R2");
    // R3 R5: 20 bits with averaging, shared lane
    res_sel = 2'b11; lane_sel = 2'b10; avg_en = 1'b1;
    run_one(3, 40, 40, "R5 20b shared avg");
    drain(0, "R5");
    // R3: 20 bits without averaging, low four zero
    lane_sel = 2'b00; avg_en = 1'b0;
    run_one(2, 20, 50, "R3 20b no avg");
    drain(0, "R3");
    // R3: 18 bits with averaging, two lanes per channel
    res_sel = 2'b00; lane_sel = 2'b01; avg_en = 1'b1;
    run_two(2, 9, 60, "R3 18b avg two-lane");
    drain(0, "R3b");
    // R8: resolution change while a frame is on the wire
    lane_sel = 2'b00; avg_en = 1'b0;
    run_one(2, 18, 70, "R8 before change");
    res_sel = 2'b01;
    run_one(2, 18, 72, "R8 after change");
    drain(0, "R8");
    // R9 R10: strobes on three consecutive cycles
    res_sel = 2'b10;
    push_one(80, "R10 burst first");
    push_one(81, "R10 burst second");
    drive(80);
    drive(81);
    drive(82);
    drain(1, "R10 burst");
    check(last_start - prev_start == 16, "R9 back-to-back gap",
          64'(last_start - prev_start), 64'd16);
    // R6: idle lines quiet
    check({lane_a0, lane_a1, lane_b0, lane_b1, fclk} == 5'b0, "R6 idle outputs",
          64'({lane_a0, lane_a1, lane_b0, lane_b1, fclk}), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule